// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the read-data output path of a synchronous static RAM. Each cycle it receives the already-registered command for that cycle (read, write or deselect), the word the memory core is returning, and a few static mode inputs. It produces the data word for the pads and a single drive-enable that stands for the tri-state control of the data pins.

Two mode inputs shape the timing. `pipe_mode` selects the output latency. When it is high, read data passes through a rising-edge output register and appears one cycle after the read command. When it is low, the data flows straight from the core to the pins in the same cycle. `single_desel` selects how a deselect turns the drivers off. In single-cycle mode the drivers drop in the same cycle the deselect arrives, one stage ahead of the read path. In dual-cycle mode the deselect goes through the same stage as a read, so the data of a preceding read is still driven for one more cycle.

An active-low output enable gates the drivers combinationally. A sleep input forces the drivers off and freezes all registered state, so the word held before sleep is still there when sleep ends.

Top module: `sram_outq`

## Requirements
- R1: While reset is applied, and afterwards until the first read reaches the output, `dq_oe` is 0 and `dq_out` is 0. The reset is applied asynchronously and released through a two-flop synchronizer.
- R2: Command encoding on `cmd_kind`: 2'b00 deselect, 2'b01 read, 2'b10 write, 2'b11 treated as deselect. With `pipe_mode`=1, a read in cycle n makes `dq_out` equal the `core_rdata` of cycle n during cycle n+1 with `dq_oe`=1, provided that in cycle n+1 `oe_n`=0, `sleep`=0, the command is not a write, and it is not a deselect in single-cycle mode.
- R3: With `pipe_mode`=0, a read cycle drives that same cycle's `core_rdata` with `dq_oe`=1 (when `oe_n`=0 and `sleep`=0), and any non-read cycle has `dq_oe`=0.
- R4: With `pipe_mode`=1 and `single_desel`=0, a deselect (2'b00 or 2'b11) right after a read still drives that read's data for the deselect cycle, and `dq_oe` is 0 in the cycle after it.
- R5: With `pipe_mode`=1 and `single_desel`=1, `dq_oe` is 0 in any cycle whose command is a deselect, even right after a read.
- R6: In every mode, `dq_oe` is 0 in any cycle whose command is a write, including the cycle right after a read.
- R7: `oe_n`=1 forces `dq_oe` to 0 combinationally. `oe_n`=0 enables drive only in cycles that carry read data under R2 or R3.
- R8: `sleep`=1 forces `dq_oe` to 0 and holds the output register and the drive flag. With `pipe_mode`=1, the first cycle after `sleep` falls drives the word captured before sleep, if a read preceded the sleep and the cycle's command allows drive.
- R9: `dq_out` is all zeros whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_rdata | input | LANES*LANE_W | Word returned by the memory core this cycle |
| cmd_kind | input | 2 | Registered command of this cycle (R2 encoding) |
| pipe_mode | input | 1 | 1 = registered output, 0 = flow-through |
| single_desel | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby: drivers off, state frozen |
| dq_out | output | LANES*LANE_W | Data toward the pins, zero when not driven |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The assertions assume that `pipe_mode` and `single_desel` are static between resets, since the latency checks compare against the previous cycle's command under the current mode. The bench changes the modes only while reset is held and lets the synchronizer release before it issues any command. The assertions also assume `cmd_kind` and `core_rdata` are stable between clock edges. The bench drives every input once per cycle, just after the rising edge, and samples the outputs at the falling edge.

// File: rtl/sram_outq_pkg.sv
package sram_outq_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SPARE = 2'b11
  } cmd_e;

  function automatic logic cmd_is_read(input cmd_e c);
    return c == CMD_READ;
  endfunction

  function automatic logic cmd_is_write(input cmd_e c);
    return c == CMD_WRITE;
  endfunction

  function automatic logic cmd_is_desel(input cmd_e c);
    return (c != CMD_READ) && (c != CMD_WRITE);
  endfunction

endpackage

// File: rtl/sram_outq_rst_sync.sv
module sram_outq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/sram_outq_flag.sv
module sram_outq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic rd_now,
  output logic drv_q
);

  logic drv_d;

  always_comb begin
    drv_d = drv_q;
    if (!hold) drv_d = rd_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_d;
  end

  // R8: the drive flag keeps its value across a sleep cycle
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> drv_q == $past(drv_q));

endmodule

// File: rtl/sram_outq_dreg.sv
module sram_outq_dreg #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);

  localparam int DW = LANES * LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] lane_d;

    always_comb begin
      lane_d = lane_q;
      if (cap_en) lane_d = din[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign dout[g*LANE_W +: LANE_W] = lane_q;
  end

  // R2: a captured word is what the register presents on the next cycle
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> dout == $past(din));

  // R8: without a capture the held word does not move
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(dout));

  logic [DW-1:0] unused_w;
  assign unused_w = '0;

endmodule

// File: rtl/sram_outq.sv
module sram_outq
  import sram_outq_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] core_rdata,
  input  logic [1:0]              cmd_kind,
  input  logic                    pipe_mode,
  input  logic                    single_desel,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DW = LANES * LANE_W;

  cmd_e          cmd;
  logic          rst_q_n;
  logic          is_rd, is_wr, is_ds;
  logic          drv_q;
  logic [DW-1:0] dat_q;
  logic          stage_ok;
  logic [DW-1:0] src;

  assign cmd   = cmd_e'(cmd_kind);
  assign is_rd = cmd_is_read(cmd);
  assign is_wr = cmd_is_write(cmd);
  assign is_ds = cmd_is_desel(cmd);

  sram_outq_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  sram_outq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .hold   (sleep),
    .rd_now (is_rd),
    .drv_q  (drv_q)
  );

  sram_outq_dreg #(.LANES(LANES), .LANE_W(LANE_W)) u_dreg (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .cap_en (is_rd & ~sleep),
    .din    (core_rdata),
    .dout   (dat_q)
  );

  // Registered path: flag from the previous read, cut early by a
  // single-cycle deselect. Flow path: the current command alone.
  always_comb begin
    if (pipe_mode) begin
      stage_ok = drv_q & ~(single_desel & is_ds);
      src      = dat_q;
    end else begin
      stage_ok = is_rd;
      src      = core_rdata;
    end
  end

  assign dq_oe  = ~oe_n & ~sleep & ~is_wr & stage_ok;
  assign dq_out = dq_oe ? src : '0;

  // Guard for checks that look one cycle back
  logic past_ok;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) past_ok <= 1'b0;
    else          past_ok <= 1'b1;
  end

  p_pipe_lat_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && pipe_mode && $past(is_rd && !sleep) && is_rd && !oe_n && !sleep
    |-> dq_oe && dq_out == $past(core_rdata));

  p_flow_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pipe_mode && is_rd && !oe_n && !sleep |-> dq_oe && dq_out == core_rdata);

  p_dcd_hold_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok && pipe_mode && !single_desel && $past(is_rd && !sleep) && is_ds
    && !oe_n && !sleep |-> dq_oe);

  p_scd_cut_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    pipe_mode && single_desel && is_ds |-> !dq_oe);

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    is_wr |-> !dq_oe);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    oe_n |-> !dq_oe);

  p_sleep_off_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    sleep |-> !dq_oe);

  p_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dq_oe |-> dq_out == '0);

endmodule

// File: tb/sram_outq_bench.sv
module sram_outq_bench;

  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  localparam logic [1:0] C_DS = 2'b00;
  localparam logic [1:0] C_RD = 2'b01;
  localparam logic [1:0] C_WR = 2'b10;
  localparam logic [1:0] C_SP = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] core_rdata;
  logic [1:0]    cmd_kind;
  logic          pipe_mode, single_desel, oe_n, sleep;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_outq #(.LANES(LANES), .LANE_W(LANE_W)) u_sram_outq (
    .clk(clk), .rst_n(rst_n), .core_rdata(core_rdata), .cmd_kind(cmd_kind),
    .pipe_mode(pipe_mode), .single_desel(single_desel), .oe_n(oe_n),
    .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // Scoreboard queues
  logic          q_oe[$];
  logic [DW-1:0] q_dat[$];
  string         q_tag[$];

  // Bench-side state of the registered path
  logic          m_drv;
  logic [DW-1:0] m_dat;

  task automatic step(input logic [1:0] c, input logic [DW-1:0] d,
                      input logic oe, input logic slp, input string tag);
    logic          e_oe;
    logic [DW-1:0] e_dat;
    logic          ds;
    @(posedge clk); #1;
    cmd_kind = c; core_rdata = d; oe_n = oe; sleep = slp;
    ds = (c == C_DS) || (c == C_SP);
    if (pipe_mode) begin
      e_oe  = !oe && !slp && (c != C_WR) && m_drv && !(single_desel && ds);
      e_dat = m_dat;
    end else begin
      e_oe  = !oe && !slp && (c == C_RD);
      e_dat = d;
    end
    if (!e_oe) e_dat = '0;
    q_oe.push_back(e_oe); q_dat.push_back(e_dat); q_tag.push_back(tag);
    if (!slp) begin
      m_drv = (c == C_RD);
      if (c == C_RD) m_dat = d;
    end
  endtask

  task automatic do_reset(input logic pm, input logic sd);
    @(posedge clk); #1;
    rst_n = 1'b0; cmd_kind = C_DS; oe_n = 1'b0; sleep = 1'b0;
    core_rdata = '0; pipe_mode = pm; single_desel = sd;
    m_drv = 1'b0; m_dat = '0;
    @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0 || dq_out !== '0) begin
      errors++;
      $display("FAIL R1 in reset: oe=%b data=%h expected oe=0 data=0", dq_oe, dq_out);
    end
    @(posedge clk); #1; rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(C_DS, 18'h3ffff, 1'b0, 1'b0, "R1 idle after reset");
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q_oe.size() > 0) begin
        logic          e_oe;
        logic [DW-1:0] e_dat;
        string         t;
        e_oe = q_oe.pop_front(); e_dat = q_dat.pop_front(); t = q_tag.pop_front();
        checks++;
        if (dq_oe !== e_oe || dq_out !== e_dat) begin
          errors++;
          $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                   t, dq_oe, dq_out, e_oe, e_dat);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: queue=%0d expected 0", q_oe.size());
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_kind = C_DS; core_rdata = '0; oe_n = 1'b0; sleep = 1'b0;
    pipe_mode = 1'b1; single_desel = 1'b1; m_drv = 1'b0; m_dat = '0;

    // Pipelined, single-cycle deselect
    do_reset(1'b1, 1'b1);
    step(C_RD, 18'h0a5a5, 1'b0, 1'b0, "R1 first read not yet out, R9");
    step(C_RD, 18'h15a5a, 1'b0, 1'b0, "R2 one-cycle latency");
    step(C_RD, 18'h00f0f, 1'b0, 1'b0, "R2 burst continues");
    step(C_DS, 18'h3ffff, 1'b0, 1'b0, "R5 deselect cuts same cycle, R9");
    step(C_RD, 18'h12345, 1'b0, 1'b0, "R5 nothing pending after deselect");
    step(C_WR, 18'h3ffff, 1'b0, 1'b0, "R6 write after read stays off, R9");
    step(C_RD, 18'h2aaaa, 1'b0, 1'b0, "R6 write left nothing pending");
    step(C_RD, 18'h15555, 1'b1, 1'b0, "R7 oe_n high blocks drive, R9");
    step(C_RD, 18'h0beef, 1'b0, 1'b0, "R7 oe_n low restores drive");
    step(C_RD, 18'h1cafe, 1'b0, 1'b1, "R8 sleep forces off, R9");
    step(C_RD, 18'h3dead, 1'b0, 1'b1, "R8 still asleep");
    step(C_RD, 18'h01111, 1'b0, 1'b0, "R8 pre-sleep word retained");
    step(C_RD, 18'h02222, 1'b0, 1'b0, "R2 after wake");
    step(C_SP, 18'h3ffff, 1'b0, 1'b0, "R5 code 2'b11 is deselect");

    // Pipelined, dual-cycle deselect
    do_reset(1'b1, 1'b0);
    step(C_RD, 18'h0c0de, 1'b0, 1'b0, "R1 first read not yet out");
    step(C_DS, 18'h3ffff, 1'b0, 1'b0, "R4 deselect still drives read data");
    step(C_DS, 18'h3ffff, 1'b0, 1'b0, "R4 off one cycle later, R9");
    step(C_RD, 18'h0f00d, 1'b0, 1'b0, "R4 read after deselects");
    step(C_SP, 18'h3ffff, 1'b0, 1'b0, "R4 code 2'b11 held like deselect");
    step(C_RD, 18'h1abcd, 1'b0, 1'b0, "R4 idle after code 2'b11");
    step(C_WR, 18'h3ffff, 1'b0, 1'b0, "R6 write after read in dual mode");
    step(C_DS, 18'h3ffff, 1'b1, 1'b0, "R7 oe_n high on idle cycle");

    // Flow-through
    do_reset(1'b0, 1'b0);
    step(C_RD, 18'h13579, 1'b0, 1'b0, "R3 same-cycle data");
    step(C_RD, 18'h2468a, 1'b0, 1'b0, "R3 back-to-back read");
    step(C_DS, 18'h3ffff, 1'b0, 1'b0, "R3 deselect off at once, R9");
    step(C_WR, 18'h3ffff, 1'b0, 1'b0, "R6 write in flow-through");
    step(C_RD, 18'h0777f, 1'b1, 1'b0, "R7 oe_n high in flow-through");
    step(C_RD, 18'h0abab, 1'b0, 1'b1, "R8 sleep in flow-through");
    step(C_RD, 18'h3f0f0, 1'b0, 1'b0, "R3 read after sleep");

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule